// File: doc/BRIEF.md
# Loadable Synchronous Up/Down Counter with Carry

This block is a small binary counter whose every state change happens on the rising clock edge. A low on the clear input empties it. A low on the load input copies a parallel data word into it. With both of its enable inputs high it steps by one, upward or downward as the direction input selects, and it wraps around at either end of its range. Clear wins over load, and load wins over counting. When either enable is low the count holds.

A combinational carry output marks the terminal count of the current direction. That is the all-ones value when counting up and zero when counting down, and the carry is gated only by the carry-enable input. This makes the block easy to cascade. The low stage's carry drives the high stage's carry-enable, and both stages share the parallel enable, so two 4-bit stages form an 8-bit counter.

A parameter can fold a modulo wrapper into the block. In reload mode the carry triggers a parallel load of a start value on the next edge, so a start value of 5 gives the eleven-state cycle 5 to 15. In decode mode a synchronous clear fires when every bit of a mask is set in the count, so the mask 1010 gives the cycle 0 to 10.

Top module: `sync_loadable_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `q` becomes 0 on that edge, whatever the other inputs are. Nothing changes `q` between edges.
- R2: When `clr_n` is 1 and `load_n` is 0 at a rising edge, `q` takes the value of `din`, whatever the enables are.
- R3: When `clr_n` and `load_n` are both 1 and either `en_p` or `en_t` is 0, `q` keeps its value across the edge.
- R4: When `clr_n`, `load_n`, `en_p` and `en_t` are all 1, `q` steps by one on the edge. It increments when `up` is 1, wrapping from all-ones to 0, and it decrements when `up` is 0, wrapping from 0 to all-ones.
- R5: `carry` is 1 exactly when `en_t` is 1 and `q` is at the terminal count: all-ones when `up` is 1, zero when `up` is 0. `en_p` has no effect on it, and it follows its inputs within the same cycle.
- R6: With `WRAP`=1, an edge at which `carry` is 1 (and neither clear nor external load is active) loads `RELOAD`. With `RELOAD`=5, counting up with both enables high gives the sequence 5,6,...,15,5.
- R7: With `WRAP`=2, an edge at which every bit set in `DEC_MASK` is also set in `q` clears `q` to 0. With `DEC_MASK`=4'b1010, counting up from 0 gives the sequence 0,1,...,10,0.
- R8: Two instances with the low stage's `carry` wired to the high stage's `en_t` and a shared `en_p` count upward as one 8-bit value {high,low}, from 0 through 255 and back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, top priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | W | Parallel load data |
| q | output | W | Current count |
| carry | output | 1 | Terminal-count carry for cascading |

## Verification
The hardest case to reach from the ports is the carry at a terminal count while `en_p` is low and the count is frozen. A free-running counter only passes through its terminal value for one cycle. The stimulus therefore uses a parallel load to put the counter at 15 (or 0) and then drops `en_p`. It toggles `en_t` and `up` around that point, which shows that the carry follows `en_t` and the direction but ignores `en_p`. Random cycles that mix loads of terminal values with rare clears reach the clear-over-load and load-over-count collisions as well.

// File: rtl/sync_loadable_counter.sv
module sync_loadable_counter #(
  parameter int W = 4,
  parameter int WRAP = 0,
  parameter logic [W-1:0] RELOAD = W'(5),
  parameter logic [W-1:0] DEC_MASK = W'(10)
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic         up,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);
  logic at_end, dec_hit, wrap_ld;

  assign at_end  = up ? (&q) : ~(|q);
  assign carry   = en_t & at_end;
  assign dec_hit = (WRAP == 2) && ((q & DEC_MASK) == DEC_MASK);
  assign wrap_ld = (WRAP == 1) && carry;

  always_ff @(posedge clk) begin
    if (!clr_n || dec_hit)  q <= '0;
    else if (!load_n)       q <= din;
    else if (wrap_ld)       q <= RELOAD;
    else if (en_p && en_t)  q <= up ? q + W'(1) : q - W'(1);
  end
endmodule

// File: rtl/ctr_props.sv
module ctr_props #(
  parameter int W = 4,
  parameter int WRAP = 0,
  parameter logic [W-1:0] RELOAD = W'(5),
  parameter logic [W-1:0] DEC_MASK = W'(10)
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic         en_p,
  input logic         en_t,
  input logic         up,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         carry
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  a_r1_clear: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> q == '0);

  a_r2_load: assert property (@(posedge clk) disable iff (!armed)
    (WRAP == 0 && clr_n && !load_n) |=> q == $past(din));

  a_r3_hold: assert property (@(posedge clk) disable iff (!armed)
    (WRAP == 0 && clr_n && load_n && !(en_p && en_t)) |=> $stable(q));

  a_r4_step: assert property (@(posedge clk) disable iff (!armed)
    (WRAP == 0 && clr_n && load_n && en_p && en_t) |=>
      q == ($past(up) ? $past(q) + W'(1) : $past(q) - W'(1)));

  a_r5_carry_gate: assert property (@(posedge clk) disable iff (!armed)
    carry |-> (en_t && ($countones(q) == W || q == '0)));

  a_r6_reload: assert property (@(posedge clk) disable iff (!armed)
    (WRAP == 1 && clr_n && load_n && carry) |=> q == RELOAD);

  a_r7_decode: assert property (@(posedge clk) disable iff (!armed)
    (WRAP == 2 && (q & DEC_MASK) == DEC_MASK) |=> q == '0);
endmodule

bind sync_loadable_counter ctr_props #(
  .W(W), .WRAP(WRAP), .RELOAD(RELOAD), .DEC_MASK(DEC_MASK)
) u_props (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
  .up(up), .din(din), .q(q), .carry(carry)
);

// File: tb/tb_sync_loadable_counter.sv
`timescale 1ns/1ps
module tb_sync_loadable_counter;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0, up = 1'b1;
  logic [3:0] din = 4'd0, q;
  logic carry;

  sync_loadable_counter dut (.clk(clk), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t), .up(up), .din(din), .q(q), .carry(carry));

  logic m_clr_n = 1'b1, m_en = 1'b0;
  logic [3:0] q_rel, q_dec;
  logic c_rel, c_dec;
  sync_loadable_counter #(.WRAP(1), .RELOAD(4'd5)) u_rel (.clk(clk), .clr_n(m_clr_n),
    .load_n(1'b1), .en_p(m_en), .en_t(m_en), .up(1'b1), .din(4'd0), .q(q_rel), .carry(c_rel));
  sync_loadable_counter #(.WRAP(2), .DEC_MASK(4'b1010)) u_dec (.clk(clk), .clr_n(m_clr_n),
    .load_n(1'b1), .en_p(m_en), .en_t(m_en), .up(1'b1), .din(4'd0), .q(q_dec), .carry(c_dec));

  logic [3:0] q_lo, q_hi;
  logic c_lo, c_hi;
  sync_loadable_counter u_lo (.clk(clk), .clr_n(m_clr_n), .load_n(1'b1), .en_p(m_en),
    .en_t(m_en), .up(1'b1), .din(4'd0), .q(q_lo), .carry(c_lo));
  sync_loadable_counter u_hi (.clk(clk), .clr_n(m_clr_n), .load_n(1'b1), .en_p(m_en),
    .en_t(c_lo), .up(1'b1), .din(4'd0), .q(q_hi), .carry(c_hi));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nxt(logic [3:0] cur, logic c, logic l, logic p,
                                     logic t, logic u, logic [3:0] d);
    if (!c) return 4'd0;
    if (!l) return d;
    if (p && t) return u ? cur + 4'd1 : cur - 4'd1;
    return cur;
  endfunction

  function automatic logic exp_carry(logic [3:0] cur, logic t, logic u);
    return t && (u ? (cur == 4'hF) : (cur == 4'h0));
  endfunction

  logic [3:0] exp_q = 4'd0;

  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic u, input logic [3:0] d, input string req);
    clr_n = c; load_n = l; en_p = p; en_t = t; up = u; din = d;
    #1;
    chk(carry === exp_carry(exp_q, t, u), "R5 carry", int'(carry), int'(exp_carry(exp_q, t, u)));
    @(posedge clk);
    exp_q = nxt(exp_q, c, l, p, t, u, d);
    @(negedge clk);
    chk(q === exp_q, req, int'(q), int'(exp_q));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step(0, 1, 1, 1, 1, 4'd9, "R1 reset to 0");
    step(0, 0, 1, 1, 1, 4'd7, "R1 clear over load");
    step(1, 0, 1, 1, 1, 4'd3, "R2 load over count");
    step(1, 0, 0, 0, 0, 4'hC, "R2 load with enables low");
    step(1, 1, 0, 1, 1, 4'd0, "R3 hold en_p low");
    step(1, 1, 1, 0, 1, 4'd0, "R3 hold en_t low");
    step(1, 0, 0, 0, 1, 4'hF, "R2 load 15");
    step(1, 1, 0, 1, 1, 4'd0, "R5 carry at 15 with en_p low, count held");
    step(1, 1, 0, 0, 1, 4'd0, "R5 no carry en_t low");
    step(1, 1, 0, 1, 0, 4'd0, "R5 no carry at 15 counting down");
    step(1, 1, 1, 1, 1, 4'd0, "R4 up wrap 15 to 0");
    step(1, 1, 0, 1, 0, 4'd0, "R5 carry at 0 counting down");
    step(1, 1, 1, 1, 0, 4'd0, "R4 down wrap 0 to 15");
    step(1, 1, 1, 1, 0, 4'd0, "R4 down step");
    for (int i = 0; i < 3000; i++) begin
      logic c, l, p, t, u;
      logic [3:0] d;
      c = ($urandom_range(0, 15) != 0);
      l = ($urandom_range(0, 5) != 0);
      p = ($urandom_range(0, 3) != 0);
      t = ($urandom_range(0, 3) != 0);
      u = $urandom_range(0, 1) != 0;
      d = ($urandom_range(0, 3) == 0) ? (u ? 4'hF : 4'h0) : 4'($urandom_range(0, 15));
      step(c, l, p, t, u, d, "R1-R4 random");
    end

    m_clr_n = 1'b0; m_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(q_rel == 4'd0 && q_dec == 4'd0 && q_lo == 4'd0 && q_hi == 4'd0,
        "R1 wrapper clear", int'({q_hi, q_lo}), 0);
    m_clr_n = 1'b1;
    @(posedge clk); @(negedge clk);
    m_en = 1'b1;
    begin
      logic [3:0] er, ed;
      logic [7:0] ec;
      er = 4'd0; ed = 4'd0; ec = 8'd0;
      for (int i = 0; i < 300; i++) begin
        @(posedge clk);
        er = (er == 4'hF) ? 4'd5 : er + 4'd1;
        ed = ((ed & 4'b1010) == 4'b1010) ? 4'd0 : ed + 4'd1;
        ec = ec + 8'd1;
        @(negedge clk);
        chk(q_rel == er, "R6 reload modulo", int'(q_rel), int'(er));
        chk(q_dec == ed, "R7 decode modulo", int'(q_dec), int'(ed));
        chk({q_hi, q_lo} == ec, "R8 cascade", int'({q_hi, q_lo}), int'(ec));
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule